// File: doc/BRIEF.md
# Programmable Interval Timer with Modulo Reload

This block is a byte-wide timer peripheral that sits on a simple processor bus. It holds four registers: a free-running divider, a counter that software can program, a reload value, and a control byte. The divider moves forward on every clock. When the control byte enables it, the counter moves forward once every N clocks, where a two-bit rate field selects N. When the counter passes its top value, it does not wrap to zero. It takes the reload value instead and raises the interrupt request for one cycle.

The bus has a 16-bit address, 8-bit write data, a write strobe and combinational read data. Software reads the divider for coarse timekeeping. It sets up periodic interrupts by choosing the reload value and the rate. The interrupt controller and the processor are outside this block.

Top module: `prog_itimer`

## Requirements
- R1: The registers decode at these addresses: 0xFF04 divider, 0xFF05 counter, 0xFF06 reload value, 0xFF07 control. A write with `bus_wr` high stores into the addressed register. Reads from any other address return 0xFF, and writes to any other address change nothing.
- R2: The divider (read at 0xFF04) increases by one on every clock and wraps from 0xFF to 0x00.
- R3: The prescaler starts from zero at a divider clear. Control bits 1:0 set the interval between counter steps: 00 gives one step per 1024 clocks, 01 per 16, 10 per 64 and 11 per 256. The first step after a clear comes N clocks after it.
- R4: Control bit 2 enables counting. While it is 0 the counter keeps its value and the divider keeps running.
- R5: When a step finds the counter at 0xFF, the counter loads the reload value held before that edge rather than wrapping to 0x00.
- R6: The interrupt output is high for exactly one cycle for each reload, in the same cycle in which the reloaded value is first visible.
- R7: A bus write to the counter in a cycle that would also step it wins. The counter takes the written byte and no interrupt is raised.
- R8: A read at 0xFF07 returns the last written bits 2:0 in bits 2:0, with bits 7:3 read as 1.
- R9: A write to 0xFF04 clears the divider and the prescaler to zero, whatever the data. No counter step happens in that cycle.
- R10: While reset is low, the divider, counter, reload value, control and prescaler are all zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one timer tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Byte address for read and write |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | One-cycle timer interrupt request |

## Verification
The checker watches several rules on every cycle:
- the interrupt output is never high for two cycles in a row;
- each interrupt appears with the counter holding the previous reload value, after a cycle at 0xFF;
- a counter write takes effect with no interrupt;
- a disabled counter holds its value;
- the divider always either increments or clears after a divider write;
- the control readback and unmapped reads are correct.

The step interval for each rate setting can only be shown by the bench's scenarios. So can the exact cycle of the first step after a clear and the case where a counter write collides with a step. The bench compares these against its cycle-level model during long runs with directed and random stimulus.

// File: rtl/prog_itimer_pkg.sv
package prog_itimer_pkg;

   localparam int CTL_W      = 3;
   localparam int CTL_EN_BIT = 2;

   typedef enum logic [1:0] {
      RS_SLOWEST = 2'b00,
      RS_FASTEST = 2'b01,
      RS_FAST    = 2'b10,
      RS_SLOW    = 2'b11
   } itm_rate_e;

   typedef struct packed {
      logic ctl;
      logic mod;
      logic cnt;
      logic div;
   } itm_wr_t;

endpackage

// File: rtl/prog_itimer_prescale.sv
module prog_itimer_prescale
   import prog_itimer_pkg::*;
#(
   parameter int PRE_W     = 10,
   parameter int DATA_W    = 8,
   parameter int LOG2_R0   = 10,
   parameter int LOG2_R1   = 4,
   parameter int LOG2_R2   = 6,
   parameter int LOG2_R3   = 8,
   parameter bit SHARE_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  itm_rate_e         rsel,
   output logic              step,
   output logic [DATA_W-1:0] div
);

   localparam logic [PRE_W-1:0] ONES  = '1;
   localparam logic [PRE_W-1:0] MASK0 = ONES >> (PRE_W - LOG2_R0);
   localparam logic [PRE_W-1:0] MASK1 = ONES >> (PRE_W - LOG2_R1);
   localparam logic [PRE_W-1:0] MASK2 = ONES >> (PRE_W - LOG2_R2);
   localparam logic [PRE_W-1:0] MASK3 = ONES >> (PRE_W - LOG2_R3);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (clr) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      case (rsel)
         RS_SLOWEST: mask = MASK0;
         RS_FASTEST: mask = MASK1;
         RS_FAST:    mask = MASK2;
         default:    mask = MASK3;
      endcase
   end

   assign step = en && !clr && ((pre_q & mask) == mask);

   generate
      if (SHARE_DIV) begin : g_div_alias
         assign div = pre_q[DATA_W-1:0];
      end else begin : g_div_own
         logic [DATA_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   div_q <= '0;
            else if (clr) div_q <= '0;
            else          div_q <= div_q + 1'b1;
         end
         assign div = div_q;
      end
   endgenerate

endmodule

// File: rtl/prog_itimer_count.sv
module prog_itimer_count #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic [DATA_W-1:0] reload_val,
   output logic [DATA_W-1:0] cnt,
   output logic              irq
);

   localparam logic [DATA_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (load) begin
            cnt <= load_val;
         end else if (step) begin
            if (cnt == TOP) begin
               cnt <= reload_val;
               irq <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/prog_itimer_regs.sv
module prog_itimer_regs
   import prog_itimer_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] div,
   input  logic [DATA_W-1:0] cnt,
   output itm_wr_t           strb,
   output logic [CTL_W-1:0]  ctl_q,
   output logic [DATA_W-1:0] mod_q,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W = DATA_W - CTL_W;

   logic       hit;
   logic [1:0] off;

   assign hit = (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
   assign off = addr[1:0];

   always_comb begin
      strb     = '0;
      strb.div = wr && hit && (off == 2'd0);
      strb.cnt = wr && hit && (off == 2'd1);
      strb.mod = wr && hit && (off == 2'd2);
      strb.ctl = wr && hit && (off == 2'd3);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q <= '0;
         ctl_q <= '0;
      end else begin
         if (strb.mod) mod_q <= wdata;
         if (strb.ctl) ctl_q <= wdata[CTL_W-1:0];
      end
   end

   always_comb begin
      rdata = '1;
      if (hit) begin
         case (off)
            2'd0:    rdata = div;
            2'd1:    rdata = cnt;
            2'd2:    rdata = mod_q;
            default: rdata = {{PAD_W{1'b1}}, ctl_q};
         endcase
      end
   end

endmodule

// File: rtl/prog_itimer.sv
module prog_itimer
   import prog_itimer_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF04,
   parameter int                PRE_W     = 10,
   parameter int                LOG2_R0   = 10,
   parameter int                LOG2_R1   = 4,
   parameter int                LOG2_R2   = 6,
   parameter int                LOG2_R3   = 8,
   parameter bit                SHARE_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   generate
      if (DATA_W <= CTL_W) begin : g_err_data_w
         $error("DATA_W must exceed the control field width");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_err_base
         $error("BASE_ADDR must be aligned to four bytes");
      end
      if (LOG2_R0 > PRE_W || LOG2_R1 > PRE_W || LOG2_R2 > PRE_W || LOG2_R3 > PRE_W) begin : g_err_pre_w
         $error("PRE_W too narrow for the slowest rate");
      end
      if (LOG2_R0 < 1 || LOG2_R1 < 1 || LOG2_R2 < 1 || LOG2_R3 < 1) begin : g_err_rate
         $error("each rate must be at least two ticks");
      end
      if (SHARE_DIV && PRE_W < DATA_W) begin : g_err_share
         $error("shared divider needs PRE_W >= DATA_W");
      end
   endgenerate

   itm_wr_t           strb;
   logic [CTL_W-1:0]  ctl_q;
   logic [DATA_W-1:0] mod_q;
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] div_q;
   logic              step;

   prog_itimer_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .wr    (bus_wr),
      .wdata (bus_wdata),
      .div   (div_q),
      .cnt   (cnt_q),
      .strb  (strb),
      .ctl_q (ctl_q),
      .mod_q (mod_q),
      .rdata (bus_rdata)
   );

   prog_itimer_prescale #(
      .PRE_W     (PRE_W),
      .DATA_W    (DATA_W),
      .LOG2_R0   (LOG2_R0),
      .LOG2_R1   (LOG2_R1),
      .LOG2_R2   (LOG2_R2),
      .LOG2_R3   (LOG2_R3),
      .SHARE_DIV (SHARE_DIV)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (strb.div),
      .en    (ctl_q[CTL_EN_BIT]),
      .rsel  (itm_rate_e'(ctl_q[1:0])),
      .step  (step),
      .div   (div_q)
   );

   prog_itimer_count #(
      .DATA_W (DATA_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .load       (strb.cnt),
      .load_val   (bus_wdata),
      .reload_val (mod_q),
      .cnt        (cnt_q),
      .irq        (irq)
   );

endmodule

// File: rtl/prog_itimer_chk.sv
module prog_itimer_chk #(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF04
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [DATA_W-1:0] cnt,
   input logic [DATA_W-1:0] mod,
   input logic [DATA_W-1:0] div,
   input logic [2:0]        ctl
);

   localparam logic [ADDR_W-1:0] DIV_A = BASE_ADDR;
   localparam logic [ADDR_W-1:0] CNT_A = BASE_ADDR + 1;
   localparam logic [ADDR_W-1:0] CTL_A = BASE_ADDR + 3;
   localparam logic [DATA_W-1:0] TOP   = '1;

   logic cnt_wr, div_wr, unmapped;
   assign cnt_wr   = bus_wr && (bus_addr == CNT_A);
   assign div_wr   = bus_wr && (bus_addr == DIV_A);
   assign unmapped = (bus_addr < BASE_ADDR) || (bus_addr > CTL_A);

   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_reload_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == $past(mod)) && ($past(cnt) == TOP));

   p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == $past(bus_wdata)) && !irq);

   p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[2] && !cnt_wr) |=> (cnt == $past(cnt)));

   p_div_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr |=> (div == '0));

   p_div_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !div_wr |=> (div == $past(div) + 1'b1));

   p_ctl_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CTL_A) |-> (bus_rdata == {{(DATA_W-3){1'b1}}, ctl}));

   p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (bus_rdata == TOP));

endmodule

bind prog_itimer prog_itimer_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .BASE_ADDR (BASE_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .cnt       (cnt_q),
   .mod       (mod_q),
   .div       (div_q),
   .ctl       (ctl_q)
);

// File: tb/prog_itimer_tb.sv
`timescale 1ns/1ps
module prog_itimer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model of the timer state
   logic [9:0] m_pre = '0;
   logic [7:0] m_cnt = '0;
   logic [7:0] m_mod = '0;
   logic [2:0] m_ctl = '0;
   logic       m_irq = 1'b0;

   always #4 clk = ~clk;

   prog_itimer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      case (a)
         16'hFF04: return m_pre[7:0];
         16'hFF05: return m_cnt;
         16'hFF06: return m_mod;
         16'hFF07: return {5'b11111, m_ctl};
         default:  return 8'hFF;
      endcase
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      case (a)
         16'hFF04: return "R2";
         16'hFF05: return "R5";
         16'hFF06: return "R1";
         16'hFF07: return "R8";
         default:  return "R1";
      endcase
   endfunction

   function automatic logic [9:0] rate_mask(input logic [1:0] rs);
      case (rs)
         2'b00:   return 10'd1023;
         2'b01:   return 10'd15;
         2'b10:   return 10'd63;
         default: return 10'd255;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step(input logic [15:0] a, input logic w, input logic [7:0] d);
      logic divw, step;
      divw = w && (a == 16'hFF04);
      step = m_ctl[2] && !divw && ((m_pre & rate_mask(m_ctl[1:0])) == rate_mask(m_ctl[1:0]));
      m_irq = 1'b0;
      if (w && a == 16'hFF05) m_cnt = d;
      else if (step) begin
         if (m_cnt == 8'hFF) begin
            m_cnt = m_mod;
            m_irq = 1'b1;
         end else m_cnt = m_cnt + 8'd1;
      end
      if (w && a == 16'hFF06) m_mod = d;
      if (w && a == 16'hFF07) m_ctl = d[2:0];
      m_pre = divw ? 10'd0 : m_pre + 10'd1;
   endtask

   // one bus cycle: entered just after a falling edge, leaves after the next one
   task automatic cyc(input logic [15:0] a, input logic w, input logic [7:0] d, input string tag);
      bus_addr  = a;
      bus_wr    = w;
      bus_wdata = d;
      #1;
      check(tag, bus_rdata, exp_rd(a));
      check("R6", {7'd0, irq}, {7'd0, m_irq});
      model_step(a, w, d);
      @(negedge clk);
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      // R10: reset values
      foreach (m_ctl[i]) ;
      bus_addr = 16'hFF04; #1; check("R10", bus_rdata, 8'h00);
      bus_addr = 16'hFF05; #1; check("R10", bus_rdata, 8'h00);
      bus_addr = 16'hFF06; #1; check("R10", bus_rdata, 8'h00);
      bus_addr = 16'hFF07; #1; check("R10", bus_rdata, 8'hF8);
      check("R10", {7'd0, irq}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: divider runs from reset, through a wrap
      for (int i = 0; i < 300; i++) cyc(16'hFF04, 1'b0, 8'h00, "R2");

      // R1/R5/R6: reload setup, fast rate
      cyc(16'hFF06, 1'b1, 8'hF0, "R1");
      cyc(16'hFF05, 1'b1, 8'hFC, "R1");
      cyc(16'hFF07, 1'b1, 8'h05, "R8");
      cyc(16'hFF04, 1'b1, 8'h3C, "R9");
      for (int i = 0; i < 120; i++) cyc(16'hFF05, 1'b0, 8'h00, "R5");

      // R3: every rate from a fresh prescaler clear
      for (int rs = 0; rs < 4; rs++) begin
         cyc(16'hFF07, 1'b1, {5'd0, 1'b1, 2'(rs)}, "R3");
         cyc(16'hFF05, 1'b1, 8'hFE, "R3");
         cyc(16'hFF04, 1'b1, 8'h00, "R3");
         for (int i = 0; i < 1100; i++) cyc(16'hFF05, 1'b0, 8'h00, "R3");
      end

      // R4: disabled counter holds while divider runs
      cyc(16'hFF07, 1'b1, 8'h01, "R4");
      for (int i = 0; i < 150; i++) cyc(16'hFF05, 1'b0, 8'h00, "R4");
      for (int i = 0; i < 20; i++)  cyc(16'hFF04, 1'b0, 8'h00, "R4");

      // R7: counter write collides with a step at the overflow point
      cyc(16'hFF07, 1'b1, 8'h05, "R7");
      cyc(16'hFF05, 1'b1, 8'hFF, "R7");
      while (m_pre[3:0] != 4'hF) cyc(16'hFF05, 1'b0, 8'h00, "R7");
      cyc(16'hFF05, 1'b1, 8'h42, "R7");
      cyc(16'hFF05, 1'b0, 8'h00, "R7");

      // R8: control readback with upper bits forced
      cyc(16'hFF07, 1'b1, 8'h00, "R8");
      cyc(16'hFF07, 1'b1, 8'hFF, "R8");
      cyc(16'hFF07, 1'b1, 8'h02, "R8");
      cyc(16'hFF07, 1'b0, 8'h00, "R8");

      // R9: divider clear whatever the data
      cyc(16'hFF04, 1'b1, 8'hA5, "R9");
      cyc(16'hFF04, 1'b0, 8'h00, "R9");

      // R1: unmapped addresses ignored
      cyc(16'hFF08, 1'b1, 8'h55, "R1");
      cyc(16'hFF03, 1'b1, 8'h66, "R1");
      cyc(16'hFF08, 1'b0, 8'h00, "R1");
      cyc(16'h0005, 1'b1, 8'h11, "R1");
      cyc(16'hFF06, 1'b0, 8'h00, "R1");
      cyc(16'hFF05, 1'b0, 8'h00, "R1");

      // constrained random traffic
      for (int i = 0; i < 6000; i++) begin
         logic [31:0] r;
         logic [15:0] a;
         logic        w;
         r = $urandom;
         case (r[3:0])
            4'd0:    a = 16'hFF04;
            4'd1:    a = 16'hFF08;
            4'd2:    a = 16'hFF03;
            4'd3, 4'd4, 4'd5: a = 16'hFF06;
            4'd6, 4'd7: a = 16'hFF07;
            default: a = 16'hFF05;
         endcase
         w = (r[11:4] < 8'd6) && !(a == 16'hFF04 && r[12]);
         cyc(a, w, r[23:16] | (a == 16'hFF07 ? 8'h04 : 8'h00), tag_of(a));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule